// File: doc/BRIEF.md
# Precharge-Cycled Bytewide Memory Bus Controller

This block sits on the host side of a bytewide nonvolatile memory whose cycles are started by the falling edge of an active-low chip enable. It accepts single-byte read and write requests over a valid/ready handshake. For each request it produces one complete pin-level cycle. The cycle has four parts: an address and write-strobe setup phase, a chip-enable-low access phase, a chip-enable-high precharge phase, and a return to idle. All phase lengths are parameters counted in clock cycles.

The memory latches the address when chip enable falls, so the controller presents the address only for the configured hold window after that edge and parks the bus at zero for the rest of the cycle. Writes are chip-enable controlled: the write strobe and the data drive are already active before chip enable falls, and the write ends when chip enable rises. A write needs no completion polling. A new request can be accepted in the last precharge cycle, so back-to-back requests run with no idle gap. Read data is sampled in the last access cycle and returned with a one-cycle valid pulse.

Top module: `membus_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_ce_no, mem_we_no and mem_oe_no are 1, mem_dq_oe_o is 0, req_ready_o is 1 and rsp_valid_o is 0.
- R2: req_ready_o is 1 only in idle or in the last precharge cycle, and it is never 1 while mem_ce_no is 0. A request is taken at a clock edge where req_valid_i and req_ready_o are both 1.
- R3: The captured address is on mem_addr_o for SETUP_CYC cycles before mem_ce_no falls and for the first HOLD_CYC cycles with mem_ce_no low. For the rest of the low period mem_addr_o is 0.
- R4: A read (req_we_i=0) holds mem_ce_no low for exactly ACCESS_CYC cycles, with mem_oe_no low and mem_we_no high. The byte on mem_dq_i in the last low cycle appears on rsp_rdata_o, and rsp_valid_o is high for exactly one cycle: the first cycle after mem_ce_no rises.
- R5: A write (req_we_i=1) drives mem_we_no low and mem_dq_oe_o high, with the captured byte on mem_dq_o, starting in the setup phase (before mem_ce_no falls) and lasting until mem_ce_no rises. mem_ce_no stays low for max(ACCESS_CYC, WSETUP_CYC) cycles. mem_oe_no stays high and no rsp_valid_o pulse follows.
- R6: After every rise, mem_ce_no stays high for at least PRE_CYC cycles. When another request is already waiting, the next fall comes exactly PRE_CYC+SETUP_CYC cycles after the rise.
- R7: mem_dq_oe_o is never 1 in a cycle where mem_oe_no is 0.
- R8: mem_ce_no is never low for more than MAX_CE_LOW_CYC consecutive cycles.
- R9: Address, write flag and write data are captured when the request is taken. Later changes on req_addr_i, req_we_i or req_wdata_i have no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_addr_i | input | 15 | Byte address |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_wdata_i | input | 8 | Write byte |
| rsp_rdata_o | output | 8 | Read byte |
| rsp_valid_o | output | 1 | One-cycle pulse with read byte |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_addr_o | output | 15 | Memory address bus |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from memory |

## Verification
The hardest situation to reach is a request taken in the last precharge cycle. That path only runs when the next request is already asserted while the previous cycle is still in precharge. The bench produces it by keeping req_valid_i high across two acceptances, a write followed at once by a read of the same address. It then measures the chip-enable-high gap and compares the returned byte with the one written. A behavioural memory model latches the address on each chip-enable fall and commits writes on the rise. This lets the bench detect address parking and any request input that changes after acceptance.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_START  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_PRE    = 2'd3
  } bus_state_e;
endpackage

// File: rtl/membus_timer.sv
module membus_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (clear_i) count_o <= '0;
    else              count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/membus_fsm.sv
module membus_fsm
  import membus_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int SETUP_CYC = 1,
  parameter int RD_LEN    = 4,
  parameter int WR_LEN    = 4,
  parameter int PRE_CYC   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             we_q_i,
  input  logic [CNT_W-1:0] count_i,
  output bus_state_e       state_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             clear_o
);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] WR_LAST    = CNT_W'(WR_LEN - 1);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_CYC - 1);

  bus_state_e state_q, state_d;
  logic       phase_end;

  always_comb begin
    unique case (state_q)
      ST_START:  phase_end = (count_i == SETUP_LAST);
      ST_ACCESS: phase_end = (count_i == (we_q_i ? WR_LAST : RD_LAST));
      ST_PRE:    phase_end = (count_i == PRE_LAST);
      default:   phase_end = 1'b0;
    endcase
  end

  assign ready_o  = (state_q == ST_IDLE) || ((state_q == ST_PRE) && phase_end);
  assign accept_o = ready_o && req_valid_i;
  assign clear_o  = phase_end || (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o)  state_d = ST_START;
      ST_START:  if (phase_end) state_d = ST_ACCESS;
      ST_ACCESS: if (phase_end) state_d = ST_PRE;
      ST_PRE:    if (phase_end) state_d = accept_o ? ST_START : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // access always leads into precharge, never straight back to setup
  assert_access_to_pre_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACCESS && state_d != ST_ACCESS) |=> (state_q == ST_PRE));
endmodule

// File: rtl/membus_drive.sv
module membus_drive
  import membus_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int HOLD_CYC = 1,
  parameter int RD_LEN   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_state_e        state_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              we_q_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  input  logic [DATA_W-1:0] wdata_q_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_valid_o
);
  localparam logic [CNT_W-1:0] HOLD_N  = CNT_W'(HOLD_CYC);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_LEN - 1);

  logic in_start, in_access, in_cycle, addr_win, rd_last;

  assign in_start  = (state_i == ST_START);
  assign in_access = (state_i == ST_ACCESS);
  assign in_cycle  = in_start || in_access;
  // address only needs to survive the hold window after the CE fall
  assign addr_win  = in_start || (in_access && (count_i < HOLD_N));
  assign rd_last   = in_access && !we_q_i && (count_i == RD_LAST);

  assign mem_ce_no   = !in_access;
  assign mem_we_no   = !(in_cycle && we_q_i);
  assign mem_oe_no   = !(in_access && !we_q_i);
  assign mem_dq_oe_o = in_cycle && we_q_i;
  assign mem_dq_o    = mem_dq_oe_o ? wdata_q_i : '0;
  assign mem_addr_o  = addr_win ? addr_q_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_last;
      if (rd_last) rsp_rdata_o <= mem_dq_i;
    end
  end

  assert_no_drive_fight_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no));
  assert_rsp_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_rsp_after_ce_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (mem_ce_no && !$past(mem_ce_no)));
  assert_addr_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> $stable(mem_addr_o));
  assert_ce_ctrl_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> $stable(mem_we_no));
endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
  import membus_pkg::*;
#(
  parameter int ADDR_W         = 15,
  parameter int DATA_W         = 8,
  parameter int SETUP_CYC      = 1,
  parameter int HOLD_CYC       = 1,
  parameter int ACCESS_CYC     = 4,
  parameter int WSETUP_CYC     = 5,
  parameter int PRE_CYC        = 2,
  parameter int MAX_CE_LOW_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_valid_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int RD_LEN = ACCESS_CYC;
  localparam int WR_LEN = (WSETUP_CYC > ACCESS_CYC) ? WSETUP_CYC : ACCESS_CYC;
  localparam int SPAN   = MAX_CE_LOW_CYC + PRE_CYC + SETUP_CYC + WR_LEN + 2;
  localparam int CNT_W  = $clog2(SPAN);

  bus_state_e        state;
  logic [CNT_W-1:0]  count;
  logic              accept, clear;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= req_we_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  membus_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .count_o (count)
  );

  membus_fsm #(
    .CNT_W     (CNT_W),
    .SETUP_CYC (SETUP_CYC),
    .RD_LEN    (RD_LEN),
    .WR_LEN    (WR_LEN),
    .PRE_CYC   (PRE_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .we_q_i      (we_q),
    .count_i     (count),
    .state_o     (state),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .clear_o     (clear)
  );

  membus_drive #(
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .HOLD_CYC (HOLD_CYC),
    .RD_LEN   (RD_LEN)
  ) u_drive (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .count_i     (count),
    .we_q_i      (we_q),
    .addr_q_i    (addr_q),
    .wdata_q_i   (wdata_q),
    .mem_dq_i    (mem_dq_i),
    .mem_ce_no   (mem_ce_no),
    .mem_we_no   (mem_we_no),
    .mem_oe_no   (mem_oe_no),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_valid_o (rsp_valid_o)
  );

  // pin-level run counters for timing checks
  localparam logic [CNT_W-1:0] HI_CAP  = CNT_W'(PRE_CYC + SETUP_CYC);
  localparam logic [CNT_W-1:0] LOW_CAP = CNT_W'(MAX_CE_LOW_CYC + 1);
  localparam logic [CNT_W-1:0] PRE_N   = CNT_W'(PRE_CYC);
  localparam logic [CNT_W-1:0] MAX_N   = CNT_W'(MAX_CE_LOW_CYC);

  logic [CNT_W-1:0] hi_run, low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run  <= HI_CAP;
      low_run <= '0;
    end else if (mem_ce_no) begin
      low_run <= '0;
      if (hi_run < HI_CAP) hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      if (low_run < LOW_CAP) low_run <= low_run + 1'b1;
    end
  end

  assert_ready_ce_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_ce_no);
  assert_precharge_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> (hi_run >= PRE_N));
  assert_ce_low_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> (low_run < MAX_N));
  assert_capture_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> $stable(addr_q));
endmodule

// File: tb/membus_ctrl_tb.sv
module membus_ctrl_tb;
  localparam int SETUP = 1, HOLD = 1, ACC = 4, WSET = 5, PRE = 2, MAXLOW = 16;
  localparam int WRLEN = (WSET > ACC) ? WSET : ACC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [14:0] req_addr_i = '0;
  logic        req_we_i = 1'b0;
  logic [7:0]  req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o, mem_ce_no, mem_we_no, mem_oe_no, mem_dq_oe_o;
  logic [7:0]  rsp_rdata_o, mem_dq_o, mem_dq_i;
  logic [14:0] mem_addr_o;

  always #4 clk = ~clk;

  membus_ctrl #(
    .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .ACCESS_CYC(ACC),
    .WSETUP_CYC(WSET), .PRE_CYC(PRE), .MAX_CE_LOW_CYC(MAXLOW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_we_i(req_we_i), .req_wdata_i(req_wdata_i),
    .rsp_rdata_o(rsp_rdata_o), .rsp_valid_o(rsp_valid_o), .mem_ce_no(mem_ce_no),
    .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no), .mem_addr_o(mem_addr_o),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0, n_fail = 0;

  // memory model and pin monitor
  logic [7:0]  mem [int];
  logic [7:0]  rd_byte = '0;
  logic [14:0] lat_addr = '0, park_addr = '0;
  logic [7:0]  last_dq = '0;
  logic        last_we_n = 1'b1, last_dq_oe = 1'b0, fall_we_n = 1'b1, prev_ce = 1'b1;
  logic        oe_bad_w = 1'b0, prev_rsp = 1'b0;
  int fall_cnt = 0, rise_cnt = 0, low_len = 0, hi_len = 100, fall_hi = 0, rise_low = 0;
  int bad_r7 = 0, bad_r2 = 0, rsp_long = 0, max_low = 0;

  assign mem_dq_i = !mem_oe_no ? rd_byte : 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_oe_no && mem_dq_oe_o) bad_r7++;
      if (!mem_ce_no && req_ready_o) bad_r2++;
      if (rsp_valid_o && prev_rsp) rsp_long++;
      prev_rsp = rsp_valid_o;
      if (!mem_ce_no) begin
        if (prev_ce) begin
          fall_cnt++;
          fall_hi   = hi_len;
          lat_addr  = mem_addr_o;
          fall_we_n = mem_we_no;
          low_len   = 0;
          oe_bad_w  = 1'b0;
          rd_byte   = mem.exists(int'(lat_addr)) ? mem[int'(lat_addr)] : 8'h00;
        end
        if (low_len == HOLD) park_addr = mem_addr_o;
        if (!fall_we_n && !mem_oe_no) oe_bad_w = 1'b1;
        last_we_n  = mem_we_no;
        last_dq    = mem_dq_o;
        last_dq_oe = mem_dq_oe_o;
        low_len++;
        if (low_len > max_low) max_low = low_len;
      end else begin
        if (!prev_ce) begin
          rise_cnt++;
          rise_low = low_len;
          if (!last_we_n && last_dq_oe) mem[int'(lat_addr)] = last_dq;
          hi_len = 0;
        end
        hi_len++;
      end
      prev_ce = mem_ce_no;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_accept();
    bit r;
    forever begin
      r = req_ready_o;
      if (r) begin @(posedge clk); break; end
      step();
    end
    step();
  endtask

  task automatic wait_rise(input int target);
    for (int i = 0; i < 80; i++) begin
      if (rise_cnt >= target) break;
      step();
    end
  endtask

  task automatic t_reset();
    chk(mem_ce_no == 1'b1,   "R1 ce_n in reset", mem_ce_no, 1);
    chk(mem_we_no == 1'b1,   "R1 we_n in reset", mem_we_no, 1);
    chk(mem_oe_no == 1'b1,   "R1 oe_n in reset", mem_oe_no, 1);
    chk(mem_dq_oe_o == 1'b0, "R1 dq_oe in reset", mem_dq_oe_o, 0);
    chk(rsp_valid_o == 1'b0, "R1 rsp_valid in reset", rsp_valid_o, 0);
    rst_n = 1'b1;
    step();
    chk(req_ready_o == 1'b1, "R1 ready after reset", req_ready_o, 1);
    chk(mem_ce_no == 1'b1,   "R1 ce_n after reset", mem_ce_no, 1);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [7:0] d);
    int rc = rise_cnt;
    bit saw_rsp = 1'b0;
    step();
    req_valid_i = 1'b1; req_we_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    wait_accept();
    req_valid_i = 1'b0; req_we_i = 1'b0; req_addr_i = ~a; req_wdata_i = ~d; // R9 scramble
    chk(mem_we_no == 1'b0 && mem_ce_no == 1'b1, "R5 we low before ce fall", mem_we_no, 0);
    chk(mem_dq_oe_o && mem_dq_o == d, "R5 data driven in setup", mem_dq_o, d);
    chk(mem_addr_o == a, "R3 address in setup", mem_addr_o, a);
    while (rise_cnt == rc) begin
      if (rsp_valid_o) saw_rsp = 1'b1;
      step();
    end
    chk(lat_addr == a,        "R9 latched write address", lat_addr, a);
    chk(last_dq == d,         "R9 write data at ce rise", last_dq, d);
    chk(!last_we_n,           "R5 we low until ce rise", last_we_n, 0);
    chk(rise_low == WRLEN,    "R5 write ce low length", rise_low, WRLEN);
    chk(!oe_bad_w,            "R5 oe high during write", oe_bad_w, 0);
    chk(park_addr == 15'd0,   "R3 address parked after hold", park_addr, 0);
    chk(!rsp_valid_o && !saw_rsp, "R5 no response for write", rsp_valid_o, 0);
    chk(req_ready_o == (PRE == 1), "R2 ready low in early precharge", req_ready_o, PRE == 1);
    for (int i = 1; i < PRE; i++) step();
    chk(req_ready_o == 1'b1, "R2 ready in last precharge cycle", req_ready_o, 1);
  endtask

  task automatic t_read(input logic [14:0] a, input logic [7:0] exp_d);
    int rc = rise_cnt;
    step();
    req_valid_i = 1'b1; req_we_i = 1'b0; req_addr_i = a; req_wdata_i = 8'h00;
    wait_accept();
    req_valid_i = 1'b0; req_we_i = 1'b1; req_addr_i = ~a; // R9 scramble
    wait_rise(rc + 1);
    chk(lat_addr == a,       "R9 latched read address", lat_addr, a);
    chk(rise_low == ACC,     "R4 read ce low length", rise_low, ACC);
    chk(fall_we_n == 1'b1,   "R4 we high during read", fall_we_n, 1);
    chk(rsp_valid_o == 1'b1, "R4 rsp_valid after ce rise", rsp_valid_o, 1);
    chk(rsp_rdata_o == exp_d, "R4 read data", rsp_rdata_o, exp_d);
    step();
    chk(rsp_valid_o == 1'b0, "R4 rsp_valid one cycle", rsp_valid_o, 0);
  endtask

  task automatic t_back_to_back(input logic [14:0] a, input logic [7:0] d);
    int rc = rise_cnt;
    bit got = 1'b0;
    logic [7:0] got_d = '0;
    step();
    req_valid_i = 1'b1; req_we_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    wait_accept();
    req_we_i = 1'b0; req_wdata_i = 8'h00;  // next request held waiting
    wait_accept();
    req_valid_i = 1'b0; req_addr_i = '0;
    for (int i = 0; i < 80 && !got; i++) begin
      if (rsp_valid_o) begin got = 1'b1; got_d = rsp_rdata_o; end
      else step();
    end
    chk(rise_cnt == rc + 2,        "R6 two cycles back to back", rise_cnt, rc + 2);
    chk(fall_hi == PRE + SETUP,    "R6 precharge gap back to back", fall_hi, PRE + SETUP);
    chk(got && got_d == d,         "R6 read right after write", got_d, d);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    t_write(15'h0000, 8'hA5);
    t_write(15'h7FFF, 8'h5A);
    t_write(15'h1234, 8'h3C);
    t_read(15'h7FFF, 8'h5A);
    t_read(15'h0000, 8'hA5);
    t_read(15'h1234, 8'h3C);
    t_back_to_back(15'h0456, 8'hC3);
    t_write(15'h1234, 8'h81);
    t_read(15'h1234, 8'h81);
    step(); step();
    chk(bad_r7 == 0,        "R7 no drive while oe low", bad_r7, 0);
    chk(bad_r2 == 0,        "R2 ready never with ce low", bad_r2, 0);
    chk(rsp_long == 0,      "R4 no multi-cycle response", rsp_long, 0);
    chk(max_low <= MAXLOW,  "R8 ce low bound", max_low, MAXLOW);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule